// File: doc/BRIEF.md
# DMA Chunk and Burst Sequencer

This block paces one DMA channel through a single block of transfers. A block is a run of microblocks, and each microblock is a run of data elements. The sequencer issues one-element read strobes to an abstract source port and one-element write strobes to an abstract destination port. It decides how these strobes are grouped, and the grouping depends on the transfer direction.

- **Memory to memory.** The transfer starts on its own. Reads and writes alternate in bursts, and each burst passes through an internal FIFO.
- **Peripheral to memory.** One chunk is read on each trigger. The chunks collect in the FIFO, which drains as a memory write burst once a full burst is held.
- **Memory to peripheral.** One chunk moves on each trigger, and each element is handed straight to the destination.

Short trailing chunks and bursts finish a microblock whose length is not a multiple of the segment size. Live counters show the elements still to be read in the current microblock and the microblocks still to go. A one-cycle pulse marks the end of the block. Address generation and descriptor handling sit outside this block.

Top module: `xfer_seq`

## Requirements
- R1: While reset is high and after its release, with the enable low, both strobes and the end pulse are 0, and both remaining counters read 0.
- R2: The configuration is captured on the clock edge that finds the enable high while idle. The block then holds blen_i+1 microblocks of ublen_i elements, and exactly that many elements are read and written. Changing the configuration inputs during the block has no effect. ublen_i must be at least 1.
- R3: In memory-to-memory mode (mode_i = 0, or 3), reads begin in the cycle after the start edge with no trigger. Each segment is min(burst size, elements left) read cycles, followed directly by the same number of write cycles.
- R4: In peripheral-to-memory mode (mode_i = 1) and memory-to-peripheral mode (mode_i = 2), no element moves until trig is seen high while the block waits for a trigger. Each accepted trigger yields min(chunk size, elements left) consecutive read cycles, starting the cycle after. A trigger seen during reads or writes is ignored.
- R5: chunk_sel and burst_sel code size 2^k for k = 0 to 4. Any value from 5 to 7 codes 16.
- R6: In peripheral-to-memory mode, once a chunk leaves the FIFO holding at least the burst size, a write burst of exactly the burst size follows at once. Bursts repeat while that level remains. Data leaves in the order it was read.
- R7: The last chunk or burst of a microblock is shortened to the elements that remain. In peripheral-to-memory mode, any FIFO residue is written as one short burst before the microblock closes.
- R8: In memory-to-peripheral mode, every read cycle is also a write cycle, with dst_data equal to src_data. The FIFO is not used.
- R9: elem_left starts at ublen_i and falls by the segment length when each read segment ends. It reloads to ublen_i at each new microblock. ublk_left starts at blen_i+1 and falls by one as each microblock completes.
- R10: eob is high for exactly one cycle, the cycle after the last write of the last microblock. No strobe follows until the enable has gone low and then high again.
- R11: Dropping the enable aborts the block at the next edge. Strobes stop, and the FIFO is emptied before the next block starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; rising level starts a block, low aborts |
| trig | input | 1 | Peripheral or software trigger |
| mode_i | input | 2 | 0 memory-to-memory, 1 peripheral-to-memory, 2 memory-to-peripheral |
| ublen_i | input | UBW | Elements per microblock |
| blen_i | input | BLW | Microblocks per block minus one |
| chunk_sel | input | 3 | Chunk size code |
| burst_sel | input | 3 | Burst size code |
| src_data | input | DW | Source data, valid in a read cycle |
| src_rd | output | 1 | Source read strobe, one element |
| dst_wr | output | 1 | Destination write strobe, one element |
| dst_data | output | DW | Destination data, valid in a write cycle |
| elem_left | output | UBW | Elements still to be read in this microblock |
| ublk_left | output | BLW+1 | Microblocks not yet complete |
| eob | output | 1 | End-of-block pulse |

## Verification
- **Strobe timing.** Strobes come straight from the state register. The first read appears in the cycle after the edge that samples the enable (memory to memory) or an accepted trigger (peripheral modes).
- **Segment changeover.** The switch from read to write happens with no idle cycle.
- **Counter updates.** Both counters change on the edge that ends a segment or a microblock. eob rises one cycle after the final write.
- **Sampling.** The bench drives and samples on the falling edge. Each directed check is placed at a counted cycle offset from the start edge or from the trigger it raised. The bench's source model and write tally advance on rising edges, like a register.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    localparam int SEG_W = 5;   // holds segment lengths 1..16

    typedef enum logic [1:0] {
        XM_M2M = 2'd0,
        XM_P2M = 2'd1,
        XM_M2P = 2'd2
    } xmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_WR,
        ST_DONE
    } xstate_e;

    typedef struct packed {
        xmode_e             mode;
        logic [SEG_W-1:0]   chunk;
        logic [SEG_W-1:0]   burst;
    } seg_cfg_t;

    function automatic logic [SEG_W-1:0] sel_len(input logic [2:0] sel);
        if (sel >= 3'd4)
            return SEG_W'(16);
        return SEG_W'(1) << sel;
    endfunction

    function automatic xmode_e decode_mode(input logic [1:0] m);
        if (m == 2'd3)
            return XM_M2M;
        return xmode_e'(m);
    endfunction

endpackage

// File: rtl/xfer_fifo.sv
module xfer_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[wp] <= din;
    end

    assign dout = mem[rp];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !clr) |-> (count < CW'(DEPTH) || pop)) else $error("fifo overflow"); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pop && !clr) |-> (count != '0)) else $error("fifo underflow"); // R6

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
    import xfer_seq_pkg::*;
#(
    parameter int UBW = 8,
    parameter int BLW = 8,
    parameter int CW  = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           chan_en,
    input  logic           trig,
    input  logic [1:0]     mode_i,
    input  logic [UBW-1:0] ublen_i,
    input  logic [BLW-1:0] blen_i,
    input  logic [2:0]     chunk_sel,
    input  logic [2:0]     burst_sel,
    input  logic [CW-1:0]  fcount,
    output logic           src_rd,
    output logic           dst_wr,
    output logic           push,
    output logic           pop,
    output logic           fifo_clr,
    output xmode_e         mode_o,
    output logic [UBW-1:0] elem_left,
    output logic [BLW:0]   ublk_left,
    output logic           eob
);

    xstate_e          st, st_n;
    seg_cfg_t         cfg, cfg_n;
    logic [UBW-1:0]   ublen_q, ublen_n, elem_q, elem_n, rem_after;
    logic [BLW:0]     ublk_q, ublk_n;
    logic [SEG_W-1:0] seg_len, seg_len_n, seg_left, seg_left_n, wr_len;
    logic             eob_q, eob_n, ub_end, go_wr;
    int               fa_push, fa_pop;

    function automatic logic [SEG_W-1:0] clip(input logic [SEG_W-1:0] len,
                                              input logic [UBW-1:0]   left);
        if (left < UBW'(len))
            return SEG_W'(left);
        return len;
    endfunction

    always_comb begin
        st_n       = st;
        cfg_n      = cfg;
        ublen_n    = ublen_q;
        elem_n     = elem_q;
        ublk_n     = ublk_q;
        seg_len_n  = seg_len;
        seg_left_n = seg_left;
        eob_n      = 1'b0;
        ub_end     = 1'b0;
        go_wr      = 1'b0;
        wr_len     = seg_len;
        fa_push    = int'(fcount) + 1;
        fa_pop     = int'(fcount) - 1;
        rem_after  = elem_q - UBW'(seg_len);

        case (st)
            ST_IDLE: if (chan_en) begin
                cfg_n.mode  = decode_mode(mode_i);
                cfg_n.chunk = sel_len(chunk_sel);
                cfg_n.burst = sel_len(burst_sel);
                ublen_n     = ublen_i;
                elem_n      = ublen_i;
                ublk_n      = {1'b0, blen_i} + (BLW+1)'(1);
                if (decode_mode(mode_i) == XM_M2M) begin
                    st_n       = ST_RD;
                    seg_len_n  = clip(sel_len(burst_sel), ublen_i);
                    seg_left_n = clip(sel_len(burst_sel), ublen_i);
                end else begin
                    st_n = ST_WAIT;
                end
            end
            ST_WAIT: if (trig) begin
                st_n       = ST_RD;
                seg_len_n  = clip(cfg.chunk, elem_q);
                seg_left_n = clip(cfg.chunk, elem_q);
            end
            ST_RD: begin
                seg_left_n = seg_left - SEG_W'(1);
                if (seg_left == SEG_W'(1)) begin
                    elem_n = rem_after;
                    case (cfg.mode)
                        XM_M2M: begin
                            go_wr  = 1'b1;
                            wr_len = seg_len;
                        end
                        XM_P2M: begin
                            if (fa_push >= int'(cfg.burst)) begin
                                go_wr  = 1'b1;
                                wr_len = cfg.burst;
                            end else if (rem_after == '0) begin
                                go_wr  = 1'b1;
                                wr_len = SEG_W'(fa_push);
                            end else begin
                                st_n = ST_WAIT;
                            end
                        end
                        default: begin
                            if (rem_after == '0) ub_end = 1'b1;
                            else                 st_n   = ST_WAIT;
                        end
                    endcase
                end
            end
            ST_WR: begin
                seg_left_n = seg_left - SEG_W'(1);
                if (seg_left == SEG_W'(1)) begin
                    if (cfg.mode == XM_M2M) begin
                        if (elem_q == '0) begin
                            ub_end = 1'b1;
                        end else begin
                            st_n       = ST_RD;
                            seg_len_n  = clip(cfg.burst, elem_q);
                            seg_left_n = clip(cfg.burst, elem_q);
                        end
                    end else if (fa_pop >= int'(cfg.burst)) begin
                        go_wr  = 1'b1;
                        wr_len = cfg.burst;
                    end else if (elem_q == '0 && fa_pop != 0) begin
                        go_wr  = 1'b1;
                        wr_len = SEG_W'(fa_pop);
                    end else if (elem_q == '0) begin
                        ub_end = 1'b1;
                    end else begin
                        st_n = ST_WAIT;
                    end
                end
            end
            default: ;
        endcase

        if (go_wr) begin
            st_n       = ST_WR;
            seg_len_n  = wr_len;
            seg_left_n = wr_len;
        end

        if (ub_end) begin
            if (ublk_q == (BLW+1)'(1)) begin
                ublk_n = '0;
                eob_n  = 1'b1;
                st_n   = ST_DONE;
            end else begin
                ublk_n = ublk_q - (BLW+1)'(1);
                elem_n = ublen_q;
                if (cfg.mode == XM_M2M) begin
                    st_n       = ST_RD;
                    seg_len_n  = clip(cfg.burst, ublen_q);
                    seg_left_n = clip(cfg.burst, ublen_q);
                end else begin
                    st_n = ST_WAIT;
                end
            end
        end

        if (!chan_en && st != ST_IDLE) begin
            st_n  = ST_IDLE;
            eob_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cfg      <= '0;
            ublen_q  <= '0;
            elem_q   <= '0;
            ublk_q   <= '0;
            seg_len  <= '0;
            seg_left <= '0;
            eob_q    <= 1'b0;
        end else begin
            st       <= st_n;
            cfg      <= cfg_n;
            ublen_q  <= ublen_n;
            elem_q   <= elem_n;
            ublk_q   <= ublk_n;
            seg_len  <= seg_len_n;
            seg_left <= seg_left_n;
            eob_q    <= eob_n;
        end
    end

    assign src_rd    = (st == ST_RD);
    assign dst_wr    = (st == ST_WR) || (st == ST_RD && cfg.mode == XM_M2P);
    assign push      = (st == ST_RD) && (cfg.mode != XM_M2P);
    assign pop       = (st == ST_WR);
    assign fifo_clr  = (st == ST_IDLE);
    assign mode_o    = cfg.mode;
    assign elem_left = elem_q;
    assign ublk_left = ublk_q;
    assign eob       = eob_q;

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> ($stable(cfg) && $stable(ublen_q)))
        else $error("config moved mid-block"); // R2
    AST_SEG_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD && cfg.mode != XM_M2M) |-> (seg_len <= cfg.chunk))
        else $error("chunk too long"); // R4
    AST_ELEM_BOUND: assert property (@(posedge clk) disable iff (rst)
        elem_q <= ublen_q) else $error("element count above length"); // R9
    AST_EOB_DRAINED: assert property (@(posedge clk) disable iff (rst)
        eob |-> (ublk_q == '0 && elem_q == '0 && fcount == '0))
        else $error("end pulse with work left"); // R7
    AST_EOB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eob |=> !eob) else $error("end pulse too long"); // R10

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_seq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int UBW   = 8,
    parameter int BLW   = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           chan_en,
    input  logic           trig,
    input  logic [1:0]     mode_i,
    input  logic [UBW-1:0] ublen_i,
    input  logic [BLW-1:0] blen_i,
    input  logic [2:0]     chunk_sel,
    input  logic [2:0]     burst_sel,
    input  logic [DW-1:0]  src_data,
    output logic           src_rd,
    output logic           dst_wr,
    output logic [DW-1:0]  dst_data,
    output logic [UBW-1:0] elem_left,
    output logic [BLW:0]   ublk_left,
    output logic           eob
);

    logic          push, pop, fifo_clr;
    logic [CW-1:0] fcount;
    logic [DW-1:0] fifo_dout;
    xmode_e        mode_q;

    xfer_ctrl #(.UBW(UBW), .BLW(BLW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .chan_en   (chan_en),
        .trig      (trig),
        .mode_i    (mode_i),
        .ublen_i   (ublen_i),
        .blen_i    (blen_i),
        .chunk_sel (chunk_sel),
        .burst_sel (burst_sel),
        .fcount    (fcount),
        .src_rd    (src_rd),
        .dst_wr    (dst_wr),
        .push      (push),
        .pop       (pop),
        .fifo_clr  (fifo_clr),
        .mode_o    (mode_q),
        .elem_left (elem_left),
        .ublk_left (ublk_left),
        .eob       (eob)
    );

    xfer_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (push),
        .pop   (pop),
        .din   (src_data),
        .dout  (fifo_dout),
        .count (fcount)
    );

    assign dst_data = (mode_q == XM_M2P) ? src_data : fifo_dout;

endmodule

// File: tb/xfer_seq_test.sv
module xfer_seq_test;
    localparam int DW = 8, UBW = 8, BLW = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst, chan_en, trig;
    logic [1:0]     mode_i;
    logic [UBW-1:0] ublen_i;
    logic [BLW-1:0] blen_i;
    logic [2:0]     chunk_sel, burst_sel;
    logic [DW-1:0]  src_data, dst_data;
    logic           src_rd, dst_wr, eob;
    logic [UBW-1:0] elem_left;
    logic [BLW:0]   ublk_left;

    xfer_seq #(.DW(DW), .UBW(UBW), .BLW(BLW)) uut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .trig(trig), .mode_i(mode_i),
        .ublen_i(ublen_i), .blen_i(blen_i), .chunk_sel(chunk_sel),
        .burst_sel(burst_sel), .src_data(src_data), .src_rd(src_rd),
        .dst_wr(dst_wr), .dst_data(dst_data), .elem_left(elem_left),
        .ublk_left(ublk_left), .eob(eob)
    );

    int  checks = 0, fails = 0;
    bit  done = 0;
    logic cnt_clr = 1'b1;
    int  rd_idx = 0, wr_idx = 0, eob_cnt = 0, order_err = 0;

    // source model: element index as data; tallies advance like registers
    assign src_data = DW'(rd_idx);
    always @(posedge clk) begin
        if (cnt_clr) begin
            rd_idx <= 0; wr_idx <= 0; eob_cnt <= 0;
        end else begin
            if (src_rd) rd_idx  <= rd_idx + 1;
            if (dst_wr) wr_idx  <= wr_idx + 1;
            if (eob)    eob_cnt <= eob_cnt + 1;
        end
    end
    always @(negedge clk) begin
        if (cnt_clr) order_err <= 0;
        else if (dst_wr && dst_data !== DW'(wr_idx)) order_err <= order_err + 1;
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_cfg(input int m, input int ub, input int bl, input int cs, input int bs);
        chan_en = 1'b0; trig = 1'b0;
        cnt_clr = 1'b1; tick();
        cnt_clr = 1'b0;
        mode_i = 2'(m); ublen_i = UBW'(ub); blen_i = BLW'(bl);
        chunk_sel = 3'(cs); burst_sel = 3'(bs);
    endtask

    task automatic finish_run();
        chan_en = 1'b0; trig = 1'b0;
        tick(); tick();
    endtask

    typedef struct packed {
        logic [1:0]  m;
        logic [7:0]  ub;
        logic [7:0]  bl;
        logic [2:0]  cs;
        logic [2:0]  bs;
        logic [15:0] total;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'd10, 8'd9, 3'd0, 3'd2, 16'd100},
        '{2'd1, 8'd7,  8'd2, 3'd1, 3'd2, 16'd21},
        '{2'd2, 8'd5,  8'd1, 3'd2, 3'd0, 16'd10},
        '{2'd1, 8'd16, 8'd0, 3'd4, 3'd2, 16'd16},
        '{2'd1, 8'd3,  8'd3, 3'd0, 3'd4, 16'd12},
        '{2'd0, 8'd5,  8'd0, 3'd0, 3'd7, 16'd5}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; chan_en = 1'b0; trig = 1'b0; mode_i = '0; ublen_i = '0;
        blen_i = '0; chunk_sel = '0; burst_sel = '0;
        tick(); tick(); tick();
        chk(!src_rd && !dst_wr && !eob && elem_left == 0 && ublk_left == 0,
            "R1 outputs in reset", int'(src_rd) + int'(dst_wr) + int'(eob), 0);
        rst = 1'b0;
        tick(); tick();
        chk(!src_rd && !dst_wr && !eob && ublk_left == 0,
            "R1 idle after reset", int'(src_rd) + int'(dst_wr), 0);

        // table walk: totals, order, single end pulse, config held (R2)
        for (int v = 0; v < NV; v++) begin
            int n;
            start_cfg(int'(VEC[v].m), int'(VEC[v].ub), int'(VEC[v].bl),
                      int'(VEC[v].cs), int'(VEC[v].bs));
            chan_en = 1'b1;
            trig = (VEC[v].m != 2'd0);
            n = 0;
            while (!eob && n < 4000) begin
                tick();
                n++;
                if (n == 3) begin
                    ublen_i = ublen_i ^ 8'h55; blen_i = blen_i ^ 8'h0f;
                    mode_i = mode_i ^ 2'd1; chunk_sel = 3'd4; burst_sel = 3'd0;
                end
            end
            repeat (5) tick();
            chk(rd_idx == int'(VEC[v].total), "R2 R3 R4 total reads", rd_idx, int'(VEC[v].total));
            chk(wr_idx == int'(VEC[v].total), "R2 R6 total writes", wr_idx, int'(VEC[v].total));
            finish_run();
            chk(order_err == 0, "R6 R8 data order", order_err, 0);
            chk(eob_cnt == 1, "R10 single end pulse", eob_cnt, 1);
        end

        // memory-to-memory cycle pattern, burst 4 over 6 elements
        begin
            int mism;
            mism = 0;
            start_cfg(0, 6, 0, 0, 2);
            chan_en = 1'b1;
            tick();
            for (int k = 0; k < 14; k++) begin
                bit er, ew;
                er = (k < 4) || k == 8 || k == 9;
                ew = (k >= 4 && k < 8) || k == 10 || k == 11;
                if (src_rd != er || dst_wr != ew || eob != (k == 12)) mism++;
                if (k == 0) chk(elem_left == 6 && ublk_left == 1, "R9 initial counts", int'(elem_left), 6);
                if (k == 4) chk(elem_left == 2, "R9 count after first burst", int'(elem_left), 2);
                if (k == 12) chk(ublk_left == 0 && elem_left == 0, "R9 counts at end", int'(ublk_left), 0);
                tick();
            end
            chk(mism == 0, "R3 R7 R10 strobe pattern", mism, 0);
            finish_run();
        end

        // peripheral-to-memory: trigger gating, burst drain, residue flush
        start_cfg(1, 5, 0, 1, 2);
        chan_en = 1'b1;
        repeat (4) tick();
        chk(rd_idx == 0 && !src_rd, "R4 no read without trigger", rd_idx, 0);
        trig = 1'b1; tick(); trig = 1'b0; tick(); tick();
        chk(rd_idx == 2 && wr_idx == 0 && elem_left == 3, "R4 R9 one chunk per trigger", rd_idx, 2);
        trig = 1'b1;
        repeat (6) tick();
        trig = 1'b0;
        chk(rd_idx == 4 && dst_wr, "R4 trigger ignored while busy", rd_idx, 4);
        tick();
        chk(wr_idx == 4 && elem_left == 1 && !src_rd && !dst_wr, "R6 full burst drained", wr_idx, 4);
        trig = 1'b1; tick(); trig = 1'b0; tick();
        chk(rd_idx == 5 && dst_wr && !src_rd, "R7 short chunk then flush", rd_idx, 5);
        tick();
        chk(eob && wr_idx == 5, "R7 R10 residue written before end", wr_idx, 5);
        finish_run();
        chk(order_err == 0, "R6 peripheral data order", order_err, 0);

        // memory-to-peripheral: direct hand-off
        start_cfg(2, 3, 0, 1, 0);
        chan_en = 1'b1; tick();
        trig = 1'b1; tick(); trig = 1'b0;
        chk(src_rd && dst_wr && dst_data == src_data, "R8 read and write together", int'(dst_wr), 1);
        tick(); tick();
        chk(rd_idx == 2 && wr_idx == 2 && elem_left == 1, "R8 R9 chunk delivered", wr_idx, 2);
        trig = 1'b1; tick(); trig = 1'b0; tick();
        chk(eob && rd_idx == 3, "R7 R10 short last chunk ends block", rd_idx, 3);
        finish_run();

        // size codes: burst code 7 gives 16, chunk code 3 gives 8
        begin
            int run;
            start_cfg(0, 20, 0, 0, 7);
            chan_en = 1'b1; tick();
            run = 0;
            while (src_rd && !dst_wr && run < 40) begin run++; tick(); end
            chk(run == 16, "R5 burst code 7", run, 16);
            chan_en = 1'b0; tick();
            chk(!src_rd && !dst_wr, "R11 abort stops strobes", int'(src_rd) + int'(dst_wr), 0);
            tick(); tick();

            start_cfg(1, 20, 0, 3, 4);
            chan_en = 1'b1; tick();
            trig = 1'b1; tick(); trig = 1'b0;
            run = 0;
            while (src_rd && run < 40) begin run++; tick(); end
            chk(run == 8 && elem_left == 12, "R5 R9 chunk code 3", run, 8);
            finish_run();
        end

        // after an abort the FIFO must hold nothing stale
        start_cfg(0, 20, 0, 0, 4);
        chan_en = 1'b1; repeat (5) tick();
        chan_en = 1'b0; tick(); tick();
        start_cfg(0, 4, 0, 0, 2);
        chan_en = 1'b1;
        repeat (12) tick();
        chk(wr_idx == 4, "R11 writes after abort", wr_idx, 4);
        finish_run();
        chk(order_err == 0, "R11 FIFO emptied by abort", order_err, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule